// File: doc/BRIEF.md
# Serial Port Interrupt Controller

This block keeps the pending-interrupt bookkeeping for a serial port. Four sources (transmit watermark reached, receive watermark reached, transmit queue drained, receive overrun) each own one pending bit and one mask bit. Event detectors elsewhere in the port pulse a per-source strobe for one cycle. The strobe latches the pending bit until software acknowledges it.

Software reaches the block through a plain 32-bit register port with single-cycle write strobes and a combinational read. It can mask sources, acknowledge pending bits by writing ones, and inject pending bits through a write-only trigger register. This lets interrupt handlers be exercised without real traffic. Each source drives its own level interrupt line. The line is registered and is high only while the source is both pending and unmasked.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is applied and right after it, the pending and mask registers read as zero and all four interrupt lines are low.
- R2: Byte offset 0x0 addresses the pending register, 0x4 the mask register and 0x8 the trigger register. Other offsets read as zero and writes to them change nothing. In all three registers bit 0 is transmit watermark, bit 1 receive watermark, bit 2 transmit drained and bit 3 receive overrun.
- R3: A write to the pending register clears each bit written as 1 and keeps each bit written as 0.
- R4: A write to the trigger register sets each pending bit written as 1 and keeps the others.
- R5: A one-cycle pulse on a source's event input sets that source's pending bit on the next clock edge.
- R6: If an event pulse and a software clear hit the same pending bit in the same cycle, the bit stays set.
- R7: Each interrupt line equals its pending bit AND its mask bit. It is registered, so it follows the registers one cycle after they change.
- R8: Reading the trigger register always returns zero.
- R9: Bits 31:4 of the pending and mask registers read as zero, and writes to those bits have no effect.
- R10: A write to the mask register stores data bits 3:0, which then read back at offset 0x4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Single-cycle register write strobe |
| reg_addr | input | AW (4) | Byte offset of the register access |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Combinational read data for reg_addr |
| hw_evt | input | 4 | Per-source event pulses, bit order as in R2 |
| irq_tx_watermark | output | 1 | Transmit watermark interrupt |
| irq_rx_watermark | output | 1 | Receive watermark interrupt |
| irq_tx_empty | output | 1 | Transmit drained interrupt |
| irq_rx_overflow | output | 1 | Receive overrun interrupt |

## Verification
The embedded properties check the behaviour of every pending bit on every cycle: an event sets it, an event beats a same-cycle clear, and a clear without an event empties it. They also check the one-cycle lag of each interrupt line behind pending AND mask, and the zero readback of the trigger register. The bench scenarios are needed for the register map as a whole. These are the offsets and bit order, the ignored upper bits and unmapped offsets, and mixed sequences of triggers, acknowledges and mask changes, where the expected pending, mask and line values come from the bench's own table.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NUM_SRC = 4;

  localparam int unsigned OFS_PEND = 0;
  localparam int unsigned OFS_MASK = 4;
  localparam int unsigned OFS_TRIG = 8;

  localparam int unsigned SRC_TXWM  = 0;
  localparam int unsigned SRC_RXWM  = 1;
  localparam int unsigned SRC_TXDRN = 2;
  localparam int unsigned SRC_RXOVR = 3;

  // Next value of one pending bit: set requests dominate an acknowledge.
  function automatic logic pend_next(logic cur, logic evt, logic trig, logic ack);
    return evt | trig | (cur & ~ack);
  endfunction

  // Level request of one line before the output register.
  function automatic logic line_req(logic pend, logic mask);
    return pend & mask;
  endfunction
endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic trig,
  input  logic ack,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= irqc_pkg::pend_next(pend, evt, trig, ack);
  end

  p_evt_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend);

  p_evt_beats_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ack) |=> pend);

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt && !trig) |=> !pend);

  p_trig_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pend);
endmodule

// File: rtl/irqc_reg_if.sv
module irqc_reg_if #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned NS = 4
) (
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [NS-1:0] wdata_lo,
  input  logic [NS-1:0] pend,
  input  logic [NS-1:0] mask,
  output logic [NS-1:0] ack_vec,
  output logic [NS-1:0] trig_vec,
  output logic          mask_we,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] A_PEND = AW'(irqc_pkg::OFS_PEND);
  localparam logic [AW-1:0] A_MASK = AW'(irqc_pkg::OFS_MASK);
  localparam logic [AW-1:0] A_TRIG = AW'(irqc_pkg::OFS_TRIG);

  logic hit_pend, hit_mask, hit_trig;

  assign hit_pend = (addr == A_PEND);
  assign hit_mask = (addr == A_MASK);
  assign hit_trig = (addr == A_TRIG);

  assign ack_vec  = (wr_en && hit_pend) ? wdata_lo : '0;
  assign trig_vec = (wr_en && hit_trig) ? wdata_lo : '0;
  assign mask_we  = wr_en && hit_mask;

  always_comb begin
    rdata = '0;
    if (hit_pend)      rdata[NS-1:0] = pend;
    else if (hit_mask) rdata[NS-1:0] = mask;
  end
endmodule

// File: rtl/irqc_out_stage.sv
module irqc_out_stage #(
  parameter int unsigned NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] pend,
  input  logic [NS-1:0] mask,
  output logic [NS-1:0] line_q
);
  logic [NS-1:0] req;

  for (genvar g = 0; g < NS; g++) begin : g_req
    assign req[g] = irqc_pkg::line_req(pend[g], mask[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= req;
  end

  p_line_lags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (line_q == $past(pend & mask)));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [3:0]    hw_evt,
  output logic          irq_tx_watermark,
  output logic          irq_rx_watermark,
  output logic          irq_tx_empty,
  output logic          irq_rx_overflow
);
  localparam int unsigned NS = irqc_pkg::NUM_SRC;

  logic [NS-1:0] pend, mask, ack_vec, trig_vec, line_q;
  logic          mask_we;
  logic          unused_hi;

  assign unused_hi = ^reg_wdata[DW-1:NS];

  irqc_reg_if #(.AW(AW), .DW(DW), .NS(NS)) u_regs (
    .wr_en    (reg_we),
    .addr     (reg_addr),
    .wdata_lo (reg_wdata[NS-1:0]),
    .pend     (pend),
    .mask     (mask),
    .ack_vec  (ack_vec),
    .trig_vec (trig_vec),
    .mask_we  (mask_we),
    .rdata    (reg_rdata)
  );

  for (genvar g = 0; g < NS; g++) begin : g_src
    irqc_src_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (hw_evt[g]),
      .trig (trig_vec[g]),
      .ack  (ack_vec[g]),
      .pend (pend[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= reg_wdata[NS-1:0];
  end

  irqc_out_stage #(.NS(NS)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .mask  (mask),
    .line_q(line_q)
  );

  assign irq_tx_watermark = line_q[irqc_pkg::SRC_TXWM];
  assign irq_rx_watermark = line_q[irqc_pkg::SRC_RXWM];
  assign irq_tx_empty     = line_q[irqc_pkg::SRC_TXDRN];
  assign irq_rx_overflow  = line_q[irqc_pkg::SRC_RXOVR];

  p_trig_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(irqc_pkg::OFS_TRIG)) |-> (reg_rdata == '0));

  p_upper_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:NS] == '0);

  p_mask_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(irqc_pkg::OFS_MASK)) |=> (mask == $past(reg_wdata[NS-1:0])));

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == AW'(irqc_pkg::OFS_MASK)) |=> $stable(mask));
endmodule

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  // {we, addr[3:0], wdata[31:0], evt[3:0], exp_pend, exp_mask, exp_lines}
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 4'h4, 32'hFFFF_FFFF, 4'h0, 4'h0, 4'hF, 4'h0}, // R10 R9 mask write
    {1'b0, 4'h0, 32'h0000_0000, 4'h1, 4'h1, 4'hF, 4'h1}, // R5 event
    {1'b1, 4'h8, 32'h0000_000A, 4'h0, 4'hB, 4'hF, 4'hB}, // R4 trigger
    {1'b1, 4'h0, 32'h0000_0003, 4'h0, 4'h8, 4'hF, 4'h8}, // R3 acknowledge
    {1'b1, 4'h0, 32'h0000_0008, 4'h8, 4'h8, 4'hF, 4'h8}, // R6 event beats ack
    {1'b1, 4'h4, 32'h0000_0005, 4'h0, 4'h8, 4'h5, 4'h0}, // R7 masking
    {1'b1, 4'h8, 32'hFFFF_FFF0, 4'h0, 4'h8, 4'h5, 4'h0}, // R9 upper bits
    {1'b1, 4'h0, 32'h0000_000F, 4'h4, 4'h4, 4'h5, 4'h4}, // R6 R3 mixed
    {1'b1, 4'hC, 32'h0000_000F, 4'h0, 4'h4, 4'h5, 4'h4}, // R2 unmapped
    {1'b1, 4'h8, 32'h0000_0007, 4'h0, 4'h7, 4'h5, 4'h5}  // R2 R7 bit order
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  hw_evt = '0;
  logic        irq_tx_watermark, irq_rx_watermark, irq_tx_empty, irq_rx_overflow;
  logic [3:0]  lines;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign lines = {irq_rx_overflow, irq_tx_empty, irq_rx_watermark, irq_tx_watermark};

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_evt(hw_evt),
    .irq_tx_watermark(irq_tx_watermark), .irq_rx_watermark(irq_rx_watermark),
    .irq_tx_empty(irq_tx_empty), .irq_rx_overflow(irq_rx_overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    logic [31:0] d;
    // R1 reset state
    #(CLK_PERIOD*2 + 2);
    read_reg(4'h0, d); chk("R1 pending at reset", d, 32'h0);
    read_reg(4'h4, d); chk("R1 mask at reset", d, 32'h0);
    chk("R1 lines at reset", {28'h0, lines}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lines after reset", {28'h0, lines}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [52:0] v;
      v = VEC[i];
      @(negedge clk);
      reg_we = v[52]; reg_addr = v[51:48]; reg_wdata = v[47:16]; hw_evt = v[15:12];
      @(negedge clk);
      reg_we = 1'b0; hw_evt = '0; reg_wdata = '0;
      @(negedge clk);
      read_reg(4'h0, d); chk($sformatf("R2 R3 R4 R5 R6 pending vec %0d", i), d, {28'h0, v[11:8]});
      read_reg(4'h4, d); chk($sformatf("R9 R10 mask vec %0d", i), d, {28'h0, v[7:4]});
      chk($sformatf("R7 lines vec %0d", i), {28'h0, lines}, {28'h0, v[3:0]});
    end

    // R8 trigger register reads zero while pending bits are set
    read_reg(4'h8, d); chk("R8 trigger readback", d, 32'h0);
    read_reg(4'hC, d); chk("R2 unmapped readback", d, 32'h0);

    // R7 one-cycle lag: clear all, then trigger source 0
    @(negedge clk); reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = 32'hF;
    @(negedge clk); reg_we = 1'b0;
    @(negedge clk); chk("R3 all cleared lines", {28'h0, lines}, 32'h0);
    reg_we = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h1;
    @(negedge clk); reg_we = 1'b0;
    read_reg(4'h0, d); chk("R4 pending set before line", d, 32'h1);
    chk("R7 line not yet high", {31'h0, irq_tx_watermark}, 32'h0);
    @(negedge clk);
    chk("R7 line high one cycle later", {31'h0, irq_tx_watermark}, 32'h1);

    // R1 asynchronous reset clears everything
    rst_n = 1'b0; #1;
    read_reg(4'h0, d); chk("R1 pending cleared by reset", d, 32'h0);
    read_reg(4'h4, d); chk("R1 mask cleared by reset", d, 32'h0);
    chk("R1 lines cleared by reset", {28'h0, lines}, 32'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule